// File: doc/BRIEF.md
# Timer Compare Output Port Unit

This block holds three 16-bit compare values and watches a free-running timer value supplied from outside. When the timer takes on a new value equal to one of the compare values, the block changes an 8-bit output port latch. Compare slot 0 drives bits high. Compare slot 1 drives the low six bits low. Compare slot 2 flips the top two bits. Each bit joins these actions only when its bit in one of two enable bytes is 1. Software can also load the whole port byte at any time.

The top two bits are not flipped by inverting the latch. Each has a hidden state flip-flop that records the last hardware operation, set or clear, and the next flip does the opposite. A software load of the port leaves this record alone, and the record can be read as a 2-bit status. When a set and a clear land on the same bit in the same cycle, the clear wins. Any hardware action on a bit overrides a software load of that bit in the same cycle. Each compare slot also drives a one-cycle match flag.

Top module: `cmpm_port_unit`

## Requirements
- R1: After reset the port reads 0x00, the toggle status reads 2'b11, and the compare registers and both enable bytes are zero. The first timer value seen after reset therefore matches all three compare slots when it is 0.
- R2: A match on slot i is the timer taking a new value, or the first value after reset, equal to compare register i. `match_flag[i]` is 1 for exactly the one cycle after such a cycle. A timer value that is held does not match again.
- R3: A slot 0 match sets every port bit whose set-enable bit is 1.
- R4: A slot 1 match clears port bits 0 to 5 wherever bits 0 to 5 of the reset/toggle-enable byte are 1. Slot 1 never changes bits 6 and 7.
- R5: A slot 2 match flips port bit 6 or 7 wherever bit 6 or 7 of the reset/toggle-enable byte is 1. The first flip after reset sets the bit.
- R6: `tog_next[0]` belongs to bit 6 and `tog_next[1]` to bit 7. A value of 1 means the next flip sets the bit, and 0 means it clears it. After each flip the value inverts. Software port loads never change it.
- R7: A slot 0 set on bit 6 or 7 also records a set, so `tog_next` for that bit becomes 0.
- R8: A write with `wr_sel`=5 loads `wr_data[7:0]` into the port. Any bit that a hardware match sets or clears in the same cycle takes the hardware value instead.
- R9: When a set and a clear hit the same bit in one cycle, the bit is cleared. For bits 6 and 7 this makes `tog_next` for that bit 1.
- R10: Port, toggle status and flags change at the clock edge that ends the match cycle, so the new values are visible in the next cycle. Register writes take effect for matches from the next cycle on.
- R11: Write select codes are: 0, 1 and 2 for the compare registers, 3 for the set-enable byte, 4 for the reset/toggle-enable byte and 5 for the port. Codes 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| timer_val | input | 16 | Current timer count |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register write select (codes in R11) |
| wr_data | input | 16 | Write data; the byte registers use bits 7:0 |
| port_out | output | 8 | Port latch |
| tog_next | output | 2 | Toggle state of bits 7:6; 1 means the next flip sets the bit |
| match_flag | output | 3 | One-cycle match pulse for each compare slot |

## Verification
The assertions check four things on every cycle. After a slot 1 match, every enabled low bit reads 0. After a slot 0 match with no slot 1 match, every enabled low bit reads 1. After each enabled flip, bit 6 carries the old toggle state and the record inverts. Without a match or a port load, the port and toggle status stay stable. Some behaviours can only be shown by the bench scenarios. These are the reset value of 2'b11 giving a first flip that sets, the record surviving software loads, hardware overriding a load in the same cycle, clear winning over set, and no second match on a held timer value. The bench also compares every output against a cycle model under random writes and timer movement.

// File: rtl/cmpm_pkg.sv
package cmpm_pkg;

    localparam int NCMP     = 3;
    localparam int TGL_BITS = 2;
    localparam int SEL_W    = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_CMP0  = 3'd0,
        SEL_CMP1  = 3'd1,
        SEL_CMP2  = 3'd2,
        SEL_SETEN = 3'd3,
        SEL_RTEN  = 3'd4,
        SEL_PORT  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic set_req;
        logic clr_req;
    } bit_op_t;

    // clear dominates set; otherwise keep the base value
    function automatic logic resolve_bit(input logic base, input bit_op_t op);
        if (op.clr_req)      return 1'b0;
        else if (op.set_req) return 1'b1;
        else                 return base;
    endfunction

    function automatic logic op_active(input bit_op_t op);
        return op.set_req | op.clr_req;
    endfunction

endpackage

// File: rtl/cmpm_match_bank.sv
module cmpm_match_bank
    import cmpm_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [TW-1:0]   timer_val,
    input  logic [NCMP-1:0] cmp_we,
    input  logic [TW-1:0]   wr_data,
    output logic [NCMP-1:0] hit
);

    logic [TW-1:0] prev_q;
    logic          seen_q;
    logic          fresh;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            seen_q <= 1'b0;
        end else begin
            prev_q <= timer_val;
            seen_q <= 1'b1;
        end
    end

    // a timer value is examined once: on arrival, or first after reset
    assign fresh = !seen_q || (timer_val != prev_q);

    for (genvar g = 0; g < NCMP; g++) begin : g_slot
        logic [TW-1:0] cmp_q;

        always_ff @(posedge clk) begin
            if (rst)            cmp_q <= '0;
            else if (cmp_we[g]) cmp_q <= wr_data;
        end

        assign hit[g] = fresh && (timer_val == cmp_q);
    end

endmodule

// File: rtl/cmpm_ctrl_regs.sv
module cmpm_ctrl_regs #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          seten_we,
    input  logic          rten_we,
    input  logic [PW-1:0] wr_byte,
    output logic [PW-1:0] set_en,
    output logic [PW-1:0] rt_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            set_en <= '0;
            rt_en  <= '0;
        end else begin
            if (seten_we) set_en <= wr_byte;
            if (rten_we)  rt_en  <= wr_byte;
        end
    end

endmodule

// File: rtl/cmpm_port_latch.sv
module cmpm_port_latch
    import cmpm_pkg::*;
#(
    parameter int PW       = 8,
    parameter int CLR_BITS = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NCMP-1:0]     hit,
    input  logic [PW-1:0]       set_en,
    input  logic [PW-1:0]       rt_en,
    input  logic                sw_we,
    input  logic [PW-1:0]       sw_data,
    output logic [PW-1:0]       port_q,
    output logic [TGL_BITS-1:0] tog_q
);

    localparam int TGL_BASE = PW - TGL_BITS;

    for (genvar b = 0; b < PW; b++) begin : g_bit
        bit_op_t op;
        logic    base;
        logic    bit_q;

        assign base = sw_we ? sw_data[b] : bit_q;

        if (b < CLR_BITS) begin : g_clr
            always_comb begin
                op.set_req = hit[0] & set_en[b];
                op.clr_req = hit[1] & rt_en[b];
            end
        end else if (b >= TGL_BASE) begin : g_tgl
            localparam int T = b - TGL_BASE;
            logic tgl_q;
            logic flip;

            assign flip = hit[2] & rt_en[b];

            always_comb begin
                op.set_req = (hit[0] & set_en[b]) | (flip & tgl_q);
                op.clr_req = flip & ~tgl_q;
            end

            // record of last hardware operation: 1 = next flip sets
            always_ff @(posedge clk) begin
                if (rst)                tgl_q <= 1'b1;
                else if (op_active(op)) tgl_q <= op.clr_req;
            end

            assign tog_q[T] = tgl_q;
        end else begin : g_set_only
            always_comb begin
                op.set_req = hit[0] & set_en[b];
                op.clr_req = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) bit_q <= 1'b0;
            else     bit_q <= resolve_bit(base, op);
        end

        assign port_q[b] = bit_q;
    end

endmodule

// File: rtl/cmpm_port_unit.sv
module cmpm_port_unit
    import cmpm_pkg::*;
#(
    parameter int TW       = 16,
    parameter int PW       = 8,
    parameter int CLR_BITS = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [TW-1:0]       timer_val,
    input  logic                wr_en,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [TW-1:0]       wr_data,
    output logic [PW-1:0]       port_out,
    output logic [TGL_BITS-1:0] tog_next,
    output logic [NCMP-1:0]     match_flag
);

    reg_sel_e        sel;
    logic [NCMP-1:0] cmp_we;
    logic [NCMP-1:0] hit;
    logic [PW-1:0]   set_en_w;
    logic [PW-1:0]   rt_en_w;
    logic            sw_we;

    assign sel   = reg_sel_e'(wr_sel);
    assign sw_we = wr_en && (sel == SEL_PORT);

    for (genvar i = 0; i < NCMP; i++) begin : g_dec
        assign cmp_we[i] = wr_en && (wr_sel == SEL_W'(i));
    end

    cmpm_match_bank #(.TW(TW)) u_match (
        .clk       (clk),
        .rst       (rst),
        .timer_val (timer_val),
        .cmp_we    (cmp_we),
        .wr_data   (wr_data),
        .hit       (hit)
    );

    cmpm_ctrl_regs #(.PW(PW)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .seten_we (wr_en && (sel == SEL_SETEN)),
        .rten_we  (wr_en && (sel == SEL_RTEN)),
        .wr_byte  (wr_data[PW-1:0]),
        .set_en   (set_en_w),
        .rt_en    (rt_en_w)
    );

    cmpm_port_latch #(.PW(PW), .CLR_BITS(CLR_BITS)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .set_en  (set_en_w),
        .rt_en   (rt_en_w),
        .sw_we   (sw_we),
        .sw_data (wr_data[PW-1:0]),
        .port_q  (port_out),
        .tog_q   (tog_next)
    );

    always_ff @(posedge clk) begin
        if (rst) match_flag <= '0;
        else     match_flag <= hit;
    end

endmodule

// File: rtl/cmpm_port_checker.sv
module cmpm_port_checker
    import cmpm_pkg::*;
#(
    parameter int PW       = 8,
    parameter int CLR_BITS = 6
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [SEL_W-1:0]    wr_sel,
    input logic [PW-1:0]       port_out,
    input logic [TGL_BITS-1:0] tog_next,
    input logic [NCMP-1:0]     match_flag,
    input logic [PW-1:0]       set_en,
    input logic [PW-1:0]       rt_en
);

    localparam int B6 = PW - TGL_BITS;

    // R4 and R9: enabled low bits read zero after a slot 1 match
    p_clear_low_r4: assert property (@(posedge clk) disable iff (rst)
        match_flag[1] |-> ((port_out[CLR_BITS-1:0] & $past(rt_en[CLR_BITS-1:0])) == '0));

    // R3: enabled low bits read one after a slot 0 match without slot 1
    p_set_low_r3: assert property (@(posedge clk) disable iff (rst)
        (match_flag[0] && !match_flag[1]) |->
        ((port_out[CLR_BITS-1:0] & $past(set_en[CLR_BITS-1:0])) == $past(set_en[CLR_BITS-1:0])));

    // R5: an enabled flip drives the bit from the old record, and R6: record inverts
    p_flip_bit6_r5: assert property (@(posedge clk) disable iff (rst)
        (match_flag[2] && $past(rt_en[B6])) |->
        (port_out[B6] == $past(tog_next[0]) && tog_next[0] == !port_out[B6]));

    // R6 and R8: without match or port load, port and toggle record hold
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (match_flag == '0 && !($past(wr_en) && $past(wr_sel) == SEL_PORT)) |->
        ($stable(port_out) && $stable(tog_next)));

    // R6: the record never moves without a slot 0 or slot 2 match
    p_tog_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (!match_flag[0] && !match_flag[2]) |-> $stable(tog_next));

endmodule

bind cmpm_port_unit cmpm_port_checker #(.PW(PW), .CLR_BITS(CLR_BITS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .port_out   (port_out),
    .tog_next   (tog_next),
    .match_flag (match_flag),
    .set_en     (set_en_w),
    .rt_en      (rt_en_w)
);

// File: tb/cmpm_port_unit_bench.sv
`timescale 1ns/1ps
module cmpm_port_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] timer_val = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  port_out;
    logic [1:0]  tog_next;
    logic [2:0]  match_flag;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    cmpm_port_unit u_cmpm_port_unit (
        .clk        (clk),
        .rst        (rst),
        .timer_val  (timer_val),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .port_out   (port_out),
        .tog_next   (tog_next),
        .match_flag (match_flag)
    );

    // ---------------- reference model ----------------
    logic [15:0] m_cmp [3];
    logic [7:0]  m_sen, m_rte, m_port;
    logic [1:0]  m_tog;
    logic [2:0]  m_flag;
    logic [15:0] m_prev;
    logic        m_seen;

    function automatic logic [9:0] model_next(input logic [7:0] port, input logic [1:0] tog,
                                              input logic [2:0] hit, input logic [7:0] sen,
                                              input logic [7:0] rte, input logic swe,
                                              input logic [7:0] swd);
        logic [7:0] p;
        logic [1:0] t;
        logic s, c;
        p = swe ? swd : port;
        t = tog;
        for (int b = 0; b < 8; b++) begin
            s = hit[0] & sen[b];
            c = 1'b0;
            if (b < 6) c = hit[1] & rte[b];
            else if (hit[2] & rte[b]) begin
                if (tog[b-6]) s = 1'b1;
                else          c = 1'b1;
            end
            if (c) begin
                p[b] = 1'b0;
                if (b >= 6) t[b-6] = 1'b1;
            end else if (s) begin
                p[b] = 1'b1;
                if (b >= 6) t[b-6] = 1'b0;
            end
        end
        return {t, p};
    endfunction

    function automatic logic [2:0] model_hit(input logic [15:0] tv, input logic seen,
                                             input logic [15:0] prev, input logic [15:0] c0,
                                             input logic [15:0] c1, input logic [15:0] c2);
        logic fr;
        fr = !seen || (tv != prev);
        return {fr && tv == c2, fr && tv == c1, fr && tv == c0};
    endfunction

    always @(posedge clk) begin
        logic [2:0] h;
        logic [9:0] nx;
        if (rst) begin
            for (int i = 0; i < 3; i++) m_cmp[i] = '0;
            m_sen = '0; m_rte = '0; m_port = '0; m_tog = 2'b11;
            m_flag = '0; m_prev = '0; m_seen = 1'b0;
        end else begin
            h  = model_hit(timer_val, m_seen, m_prev, m_cmp[0], m_cmp[1], m_cmp[2]);
            nx = model_next(m_port, m_tog, h, m_sen, m_rte,
                            wr_en && wr_sel == 3'd5, wr_data[7:0]);
            m_port = nx[7:0];
            m_tog  = nx[9:8];
            m_flag = h;
            m_prev = timer_val;
            m_seen = 1'b1;
            if (wr_en) begin
                case (wr_sel)
                    3'd0, 3'd1, 3'd2: m_cmp[wr_sel] = wr_data;
                    3'd3: m_sen = wr_data[7:0];
                    3'd4: m_rte = wr_data[7:0];
                    default: ;
                endcase
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk({cur_req, " port"}, port_out, m_port);
        chk({cur_req, " tog"}, tog_next, m_tog);
        chk({cur_req, " flag"}, match_flag, m_flag);
    endtask

    // drive one cycle from a negedge, then check at the following negedge
    task automatic cyc(input logic [15:0] tv, input logic we, input logic [2:0] sel,
                       input logic [15:0] d);
        timer_val = tv; wr_en = we; wr_sel = sel; wr_data = d;
        @(negedge clk);
        check_all();
    endtask

    task automatic tick(input logic [15:0] tv);
        cyc(tv, 1'b0, 3'd0, 16'h0);
    endtask

    task automatic wr(input logic [15:0] tv, input logic [2:0] sel, input logic [15:0] d);
        cyc(tv, 1'b1, sel, d);
    endtask

    logic done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] tv;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state, all compares zero so timer 0 matches all slots
        cur_req = "R1";
        tick(16'd0);
        chk("R1 flags on zero", match_flag, 3'b111);
        chk("R1 port", port_out, 8'h00);
        chk("R1 tog", tog_next, 2'b11);

        // R2: held timer does not match again
        cur_req = "R2";
        tick(16'd0);
        chk("R2 held", match_flag, 3'b000);

        cur_req = "R11";
        wr(16'd1, 3'd0, 16'd10);
        wr(16'd2, 3'd1, 16'd20);
        wr(16'd3, 3'd2, 16'd30);
        wr(16'd4, 3'd3, 16'h00C3);
        wr(16'd5, 3'd4, 16'h00C6);
        wr(16'd6, 3'd7, 16'h00AA);
        wr(16'd7, 3'd6, 16'h0000);
        chk("R11 ignored sel", port_out, 8'h00);

        // R3, R7, R10: slot 0 sets enabled bits, record for 6/7 becomes 0
        cur_req = "R3";
        tick(16'd10);
        chk("R3 set", port_out, 8'hC3);
        chk("R7 tog after set", tog_next, 2'b00);
        chk("R10 flag", match_flag, 3'b001);
        cur_req = "R2";
        tick(16'd10);
        chk("R2 no repeat", match_flag, 3'b000);

        // R4: clear enabled low bits only
        cur_req = "R4";
        tick(16'd20);
        chk("R4 clear", port_out, 8'hC1);

        // R5/R6: flip with record 0 clears top bits
        cur_req = "R5";
        tick(16'd30);
        chk("R5 flip clear", port_out, 8'h01);
        chk("R6 tog inverted", tog_next, 2'b11);

        // R6: software load does not touch record
        cur_req = "R6";
        wr(16'd31, 3'd5, 16'h00FF);
        chk("R6 sw load", port_out, 8'hFF);
        chk("R6 tog kept", tog_next, 2'b11);
        tick(16'd30);
        chk("R6 flip sets", tog_next, 2'b00);
        wr(16'd29, 3'd5, 16'h0000);
        tick(16'd30);
        chk("R6 flip clears despite sw", port_out, 8'h00);
        chk("R6 tog back", tog_next, 2'b11);

        // R8: hardware beats software on touched bits
        cur_req = "R8";
        wr(16'd20, 3'd5, 16'h00FF);
        chk("R8 precedence", port_out, 8'hF9);

        // R9: set and clear on same bits -> clear
        cur_req = "R9";
        wr(16'd21, 3'd0, 16'd40);
        wr(16'd22, 3'd1, 16'd40);
        wr(16'd23, 3'd3, 16'h0006);
        wr(16'd24, 3'd5, 16'h00FF);
        tick(16'd40);
        chk("R9 clear wins", port_out, 8'hF9);
        wr(16'd41, 3'd2, 16'd50);
        wr(16'd42, 3'd0, 16'd50);
        wr(16'd43, 3'd3, 16'h0040);
        wr(16'd44, 3'd4, 16'h0040);
        wr(16'd45, 3'd5, 16'h0000);
        tick(16'd50);
        chk("R9 bit6 set+flip", port_out, 8'h40);
        chk("R9 tog6", tog_next[0], 1'b0);
        tick(16'd51);
        tick(16'd50);
        chk("R9 bit6 set vs clear", port_out, 8'h00);
        chk("R9 tog6 clear", tog_next[0], 1'b1);

        // random phase
        cur_req = "R10 random";
        tv = 16'd0;
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 65)      tv = (tv + 16'd1) & 16'h3F;
            else if (r < 85) tv = 16'($urandom_range(0, 63));
            if ($urandom_range(0, 3) == 0) begin
                logic [2:0] s;
                logic [15:0] d;
                s = 3'($urandom_range(0, 7));
                d = 16'($urandom);
                if (s <= 3'd2) d = d & 16'h3F;
                wr(tv, s, d);
            end else begin
                tick(tv);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule